// File: doc/BRIEF.md
# SDRAM Mode Register and Burst Column Sequencer

This block sits on the device side of a synchronous DRAM. It watches the decoded command strobes, captures the operating mode when a mode-register-set command arrives while every bank is idle, and from then on turns each read or write command into the series of column addresses that the data path walks through, one per clock. It reports the current column, whether a burst is running and whether that burst is a write. It also reports the programmed CAS latency, which the read data path uses to delay its output.

The mode word selects the burst length (1, 2, 4, 8 or a whole 256-column page), the order in which columns inside a burst are visited (sequential or interleaved), the CAS latency (2 or 3), and a mode where writes always touch a single column while reads keep the programmed length. A new read or write restarts the sequence from its own column, and a burst stop or a precharge ends it. While the clock enable is low, the block freezes.

A three-state machine drives the burst: ST_IDLE, ST_READ and ST_WRITE. It has five transitions. OPEN goes from ST_IDLE to ST_READ or ST_WRITE on a column command. RESTART goes from a busy state to ST_READ or ST_WRITE on a new column command. END returns to ST_IDLE after the last beat of a fixed-length burst. CUT returns to ST_IDLE on a burst stop or a precharge. HOLD keeps every state unchanged while the clock enable is low.

Top module: `sdr_burst_seq`

## Requirements
- R1: After reset the block is idle (`burst_act`=0, `burst_wr`=0, `mrs_err`=0). The mode is burst length 1, sequential order, CAS latency 3 and normal writes.
- R2: A mode-register-set command with `cke`=1 and `banks_idle`=1 loads the mode from `addr`, and the new mode applies from the next cycle. `addr[2:0]` is the length code (000=1, 001=2, 010=4, 011=8, 111=full page). `addr[3]` is the order (0 sequential, 1 interleaved). `addr[6:4]` is the latency (010=2, 011=3), and `cas_lat` shows it as the value 2 or 3. `addr[9]`=1 selects single-column writes. `addr[8:7]` must be 00.
- R3: A mode-register-set command with a reserved length code (100, 101, 110), a reserved latency code or nonzero `addr[8:7]` raises `mrs_err` for exactly one cycle and leaves every mode setting unchanged.
- R4: A mode-register-set command with `banks_idle`=0 is ignored. The mode is unchanged and `mrs_err` stays 0.
- R5: A read or write command with `cke`=1 gives, from the next cycle, `burst_act`=1 and `col_addr` equal to `addr[7:0]`, with `burst_wr` high for a write. A fixed-length burst of L beats holds `burst_act` for exactly L cycles.
- R6: In sequential order with fixed length L, beat k has low log2(L) bits equal to (start+k) mod L. The upper bits stay equal to the start column.
- R7: In interleaved order with fixed length L, beat k has low log2(L) bits equal to the start's low bits XOR k. The upper bits stay equal to the start column.
- R8: A full-page burst visits (start+k) mod 256 and wraps without ending, whatever the order bit.
- R9: With single-column writes selected, every write burst lasts one cycle, and reads keep the programmed length.
- R10: A read or write command during a burst restarts the sequence from its own column and kind, using the current mode.
- R11: A burst stop or a precharge command ends a running burst, so `burst_act` is 0 from the next cycle.
- R12: While `cke`=0 every command is ignored and all outputs and internal state hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; low freezes the block |
| cmd_mrs | input | 1 | Decoded mode-register-set command |
| cmd_rd | input | 1 | Decoded read command |
| cmd_wr | input | 1 | Decoded write command |
| cmd_bst | input | 1 | Decoded burst stop command |
| cmd_pre | input | 1 | Decoded precharge command |
| banks_idle | input | 1 | High when all banks are precharged |
| addr | input | 10 | Address bus: mode key or start column |
| col_addr | output | 8 | Column of the current beat |
| burst_act | output | 1 | A burst is in progress |
| burst_wr | output | 1 | The running burst is a write |
| cas_lat | output | 2 | Programmed CAS latency (2 or 3) |
| mrs_err | output | 1 | One-cycle flag for a rejected mode word |

## Verification
The assertions assume that at most one command strobe is high in any cycle, which the command decoder guarantees. They also assume that a mode-register-set command with `banks_idle` high never overlaps a running burst. The stimulus drives exactly one strobe per command cycle. It only programs the mode between bursts, and it lowers `banks_idle` only to show that such a command is refused. It holds `cke` low only while the data path would be paused, including cycles that carry a read and a mode command, to show that the freeze holds.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } burst_st_e;

    typedef struct packed {
        logic [2:0] len_code;   // 0..3 = 1,2,4,8 beats; 7 = whole page
        logic       intlv;      // 1 = interleaved visiting order
        logic [1:0] cl;         // latency value, 2 or 3
        logic       single_wr;  // writes touch one column only
    } mode_cfg_t;

    localparam logic [2:0] LEN_PAGE = 3'b111;

    localparam mode_cfg_t MODE_RESET = '{
        len_code:  3'b000,
        intlv:     1'b0,
        cl:        2'd3,
        single_wr: 1'b0
    };

    function automatic logic len_code_ok(input logic [2:0] code);
        return (!code[2]) || (code == LEN_PAGE);
    endfunction

    function automatic logic cl_code_ok(input logic [2:0] code);
        return (code == 3'b010) || (code == 3'b011);
    endfunction

endpackage

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              mrs_go,
    input  logic [ADDR_W-1:0] addr,
    output mode_cfg_t         cfg,
    output logic              mrs_err
);

    logic      key_ok;
    mode_cfg_t cfg_new;

    always_comb begin
        key_ok = len_code_ok(addr[2:0]) && cl_code_ok(addr[6:4]) && (addr[8:7] == 2'b00);
        cfg_new.len_code  = addr[2:0];
        cfg_new.intlv     = addr[3];
        cfg_new.cl        = addr[5:4];
        cfg_new.single_wr = addr[9];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg     <= MODE_RESET;
            mrs_err <= 1'b0;
        end else if (cke) begin
            mrs_err <= mrs_go && !key_ok;
            if (mrs_go && key_ok) begin
                cfg <= cfg_new;
            end
        end
    end

endmodule

// File: rtl/sdr_col_gen.sv
module sdr_col_gen
    import sdr_seq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] start,
    input  logic [COL_W-1:0] beat,
    input  logic [2:0]       len_code,
    input  logic             intlv,
    output logic [COL_W-1:0] col,
    output logic             last_beat
);

    logic [COL_W-1:0] wrap_mask;
    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] ilv_col;
    logic [COL_W-1:0] ordered;

    always_comb begin
        if (len_code == LEN_PAGE) begin
            wrap_mask = '1;
        end else begin
            wrap_mask = COL_W'((1 << len_code[1:0]) - 1);
        end
        seq_col   = start + beat;
        ilv_col   = start ^ beat;
        ordered   = intlv ? ilv_col : seq_col;
        last_beat = (len_code != LEN_PAGE) && (beat == wrap_mask);
    end

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col[b] = wrap_mask[b] ? ordered[b] : start[b];
    end

endmodule

// File: rtl/sdr_burst_fsm.sv
module sdr_burst_fsm
    import sdr_seq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             go_rd,
    input  logic             go_wr,
    input  logic             go_stop,
    input  mode_cfg_t        cfg,
    input  logic [COL_W-1:0] col_in,
    input  logic             last_beat,
    output burst_st_e        state,
    output logic [COL_W-1:0] start,
    output logic [COL_W-1:0] beat,
    output logic [2:0]       len_code,
    output logic             intlv
);

    burst_st_e state_nx;
    logic      col_cmd;
    logic      busy;

    always_comb begin
        col_cmd  = go_rd || go_wr;
        busy     = (state != ST_IDLE);
        state_nx = state;
        if (cke) begin
            unique case (state)
                ST_IDLE: begin
                    if (go_rd)      state_nx = ST_READ;   // OPEN
                    else if (go_wr) state_nx = ST_WRITE;  // OPEN
                end
                ST_READ, ST_WRITE: begin
                    if (go_rd)          state_nx = ST_READ;   // RESTART
                    else if (go_wr)     state_nx = ST_WRITE;  // RESTART
                    else if (go_stop)   state_nx = ST_IDLE;   // CUT
                    else if (last_beat) state_nx = ST_IDLE;   // END
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start    <= '0;
            beat     <= '0;
            len_code <= 3'b000;
            intlv    <= 1'b0;
        end else if (cke) begin
            if (col_cmd) begin
                start    <= col_in;
                beat     <= '0;
                len_code <= (go_wr && cfg.single_wr) ? 3'b000 : cfg.len_code;
                intlv    <= cfg.intlv && (cfg.len_code != LEN_PAGE);
            end else if (busy && !go_stop) begin
                beat <= beat + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int COL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cmd_mrs,
    input  logic              cmd_rd,
    input  logic              cmd_wr,
    input  logic              cmd_bst,
    input  logic              cmd_pre,
    input  logic              banks_idle,
    input  logic [ADDR_W-1:0] addr,
    output logic [COL_W-1:0]  col_addr,
    output logic              burst_act,
    output logic              burst_wr,
    output logic [1:0]        cas_lat,
    output logic              mrs_err
);

    mode_cfg_t        cfg;
    burst_st_e        state;
    logic [COL_W-1:0] start;
    logic [COL_W-1:0] beat;
    logic [2:0]       len_code;
    logic             intlv;
    logic             last_beat;
    logic             mrs_go;
    logic             stop_any;

    assign mrs_go   = cmd_mrs && banks_idle;
    assign stop_any = cmd_bst || cmd_pre;

    sdr_mode_reg #(.ADDR_W(ADDR_W)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .cke     (cke),
        .mrs_go  (mrs_go),
        .addr    (addr),
        .cfg     (cfg),
        .mrs_err (mrs_err)
    );

    sdr_burst_fsm #(.COL_W(COL_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke       (cke),
        .go_rd     (cmd_rd),
        .go_wr     (cmd_wr),
        .go_stop   (stop_any),
        .cfg       (cfg),
        .col_in    (addr[COL_W-1:0]),
        .last_beat (last_beat),
        .state     (state),
        .start     (start),
        .beat      (beat),
        .len_code  (len_code),
        .intlv     (intlv)
    );

    sdr_col_gen #(.COL_W(COL_W)) u_col (
        .start     (start),
        .beat      (beat),
        .len_code  (len_code),
        .intlv     (intlv),
        .col       (col_addr),
        .last_beat (last_beat)
    );

    always_comb begin
        burst_act = (state != ST_IDLE);
        burst_wr  = (state == ST_WRITE);
        cas_lat   = cfg.cl;
    end

endmodule

// File: rtl/sdr_burst_seq_chk.sv
module sdr_burst_seq_chk #(
    parameter int ADDR_W = 10,
    parameter int COL_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cmd_mrs,
    input logic              cmd_rd,
    input logic              cmd_wr,
    input logic              cmd_bst,
    input logic              cmd_pre,
    input logic              banks_idle,
    input logic [ADDR_W-1:0] addr,
    input logic [COL_W-1:0]  col_addr,
    input logic              burst_act,
    input logic              burst_wr,
    input logic [1:0]        cas_lat,
    input logic              mrs_err
);

    // Input assumption behind R5: one command strobe at a time
    p_cmd_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_mrs, cmd_rd, cmd_wr, cmd_bst, cmd_pre}));

    p_read_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && cmd_rd) |=> (burst_act && !burst_wr && col_addr == $past(addr[COL_W-1:0])));

    p_write_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
        burst_wr |-> burst_act);

    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && burst_act && cmd_wr) |=> (burst_wr && col_addr == $past(addr[COL_W-1:0])));

    p_cut_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && (cmd_bst || cmd_pre)) |=> !burst_act);

    p_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> ($stable(col_addr) && $stable(burst_act) && $stable(burst_wr)
                  && $stable(cas_lat) && $stable(mrs_err)));

    p_busy_mrs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && cmd_mrs && !banks_idle) |=> ($stable(cas_lat) && !mrs_err));

    p_cl_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cas_lat[1]);

    p_err_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && mrs_err && !cmd_mrs) |=> !mrs_err);

endmodule

bind sdr_burst_seq sdr_burst_seq_chk #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .cmd_mrs    (cmd_mrs),
    .cmd_rd     (cmd_rd),
    .cmd_wr     (cmd_wr),
    .cmd_bst    (cmd_bst),
    .cmd_pre    (cmd_pre),
    .banks_idle (banks_idle),
    .addr       (addr),
    .col_addr   (col_addr),
    .burst_act  (burst_act),
    .burst_wr   (burst_wr),
    .cas_lat    (cas_lat),
    .mrs_err    (mrs_err)
);

// File: tb/tb_sdr_burst_seq.sv
`timescale 1ns/1ps
module tb_sdr_burst_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic       cmd_mrs = 1'b0, cmd_rd = 1'b0, cmd_wr = 1'b0, cmd_bst = 1'b0, cmd_pre = 1'b0;
    logic       banks_idle = 1'b1;
    logic [9:0] addr = '0;
    logic [7:0] col_addr;
    logic       burst_act, burst_wr, mrs_err;
    logic [1:0] cas_lat;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sdr_burst_seq dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cmd_mrs(cmd_mrs), .cmd_rd(cmd_rd),
        .cmd_wr(cmd_wr), .cmd_bst(cmd_bst), .cmd_pre(cmd_pre), .banks_idle(banks_idle),
        .addr(addr), .col_addr(col_addr), .burst_act(burst_act), .burst_wr(burst_wr),
        .cas_lat(cas_lat), .mrs_err(mrs_err)
    );

    // Behavioural reference model
    int    m_len = 1;     // programmed beats, 256 = page
    bit    m_ilv = 0;
    int    m_cl  = 3;
    bit    m_sw  = 0;
    bit    m_err = 0;
    bit    m_act = 0;
    bit    m_wr  = 0;
    bit    m_page = 0;
    bit    m_bilv = 0;
    int    m_blen = 1;
    int    m_start = 0;
    int    m_k = 0;
    string m_tag = "R5";

    function automatic int exp_col();
        int msk;
        if (m_page) return (m_start + m_k) % 256;
        msk = m_blen - 1;
        if (m_bilv) return (m_start & ~msk) | ((m_start ^ m_k) & msk);
        return (m_start & ~msk) | ((m_start + m_k) & msk);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_len = 1; m_ilv = 0; m_cl = 3; m_sw = 0; m_err = 0;
            m_act = 0; m_wr = 0; m_page = 0; m_bilv = 0; m_blen = 1; m_k = 0;
        end else if (cke) begin
            m_err = 0;
            if (cmd_mrs && banks_idle) begin
                int lc, cc;
                bit ok;
                lc = addr[2:0];
                cc = addr[6:4];
                ok = (lc <= 3 || lc == 7) && (cc == 2 || cc == 3) && addr[8:7] == 0;
                if (!ok) m_err = 1;
                else begin
                    m_len = (lc == 7) ? 256 : (1 << lc);
                    m_ilv = addr[3];
                    m_cl  = cc;
                    m_sw  = addr[9];
                end
            end
            if (cmd_rd || cmd_wr) begin
                m_tag   = m_act ? "R10" : ((cmd_wr && m_sw) ? "R9" : "R5");
                m_act   = 1;
                m_wr    = cmd_wr;
                m_start = addr[7:0];
                m_k     = 0;
                m_blen  = (cmd_wr && m_sw) ? 1 : m_len;
                m_page  = (m_blen == 256);
                m_bilv  = m_ilv && !m_page;
            end else if (cmd_bst || cmd_pre) begin
                if (m_act) m_tag = "R11";
                m_act = 0;
                m_wr  = 0;
            end else if (m_act) begin
                if (!m_page && m_k == m_blen - 1) begin
                    m_act = 0;
                    m_wr  = 0;
                end else begin
                    m_k = (m_k + 1) % 256;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            string ctag;
            ctag = (m_tag == "R10") ? "R10" : (m_page ? "R8" : (m_bilv ? "R7" : "R6"));
            if (!cke) ctag = "R12";
            chk(burst_act == m_act, cke ? m_tag : "R12", "burst_act", burst_act, m_act);
            chk(burst_wr == m_wr, cke ? m_tag : "R12", "burst_wr", burst_wr, m_wr);
            chk(int'(cas_lat) == m_cl, "R2", "cas_lat", cas_lat, m_cl);
            chk(mrs_err == m_err, "R3", "mrs_err", mrs_err, m_err);
            if (m_act) chk(int'(col_addr) == exp_col(), ctag, "col_addr", col_addr, exp_col());
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_cmds();
        cmd_mrs = 0; cmd_rd = 0; cmd_wr = 0; cmd_bst = 0; cmd_pre = 0;
    endtask

    task automatic do_mrs(input logic [9:0] key);
        cmd_mrs = 1; addr = key; step(1); clear_cmds();
    endtask
    task automatic do_rd(input logic [7:0] c);
        cmd_rd = 1; addr = {2'b00, c}; step(1); clear_cmds();
    endtask
    task automatic do_wr(input logic [7:0] c);
        cmd_wr = 1; addr = {2'b00, c}; step(1); clear_cmds();
    endtask
    task automatic do_bst();
        cmd_bst = 1; step(1); clear_cmds();
    endtask
    task automatic do_pre();
        cmd_pre = 1; step(1); clear_cmds();
    endtask

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        // R1: reset state
        chk(burst_act == 0 && burst_wr == 0 && mrs_err == 0, "R1", "idle flags", burst_act, 0);
        chk(cas_lat == 2'd3, "R1", "reset latency", cas_lat, 3);
        // R1/R5: default single-beat read
        do_rd(8'h35); step(3);
        // R2, R6: length 4 sequential, latency 2
        do_mrs(10'h022); step(1);
        do_rd(8'h0E); step(5);
        do_wr(8'h13); step(5);
        // R2, R7: length 8 interleaved, latency 3
        do_mrs(10'h03B); step(1);
        do_rd(8'h45); step(10);
        do_wr(8'hFA); step(10);
        // R6: length 2 sequential across the pair boundary
        do_mrs(10'h031); step(1);
        do_rd(8'h7F); step(3);
        // R3: reserved length, reserved latency, test bits; settings must hold
        do_mrs(10'h034); step(2);
        do_mrs(10'h043); step(2);
        do_mrs(10'h0B1); step(2);
        do_rd(8'h20); step(3);
        // R4: refused while banks are open
        banks_idle = 0; do_mrs(10'h022); banks_idle = 1; step(2);
        do_rd(8'h21); step(3);
        // R9: single-column writes, reads keep length 8
        do_mrs(10'h233); step(1);
        do_wr(8'h0A); step(3);
        do_rd(8'h0A); step(10);
        // R10: restarts in the middle of bursts
        do_rd(8'h10); step(2);
        do_rd(8'h2C); step(1);
        do_wr(8'h51); step(4);
        do_mrs(10'h03B); step(1);
        do_wr(8'h66); do_rd(8'h93); step(10);
        // R11: burst stop and precharge cut bursts
        do_rd(8'h40); step(2); do_bst(); step(3);
        do_wr(8'h48); step(1); do_pre(); step(3);
        // R8: full page, sequential then with order bit set, wraps past 255
        do_mrs(10'h037); step(1);
        do_rd(8'hF0); step(300); do_bst(); step(2);
        do_mrs(10'h03F); step(1);
        do_wr(8'h03); step(20); do_pre(); step(2);
        // R12: clock enable low freezes burst and ignores commands
        do_mrs(10'h023); step(1);
        do_rd(8'h84); step(2);
        cke = 0; step(2);
        cmd_rd = 1; addr = 10'h0C0; step(1); clear_cmds();
        cmd_mrs = 1; addr = 10'h034; step(1); clear_cmds();
        cmd_bst = 1; step(1); clear_cmds();
        cke = 1; step(10);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule